// File: doc/BRIEF.md
# Aliased Wide Vector Register File

This block holds sixteen 256-bit vector registers. The low 128 bits of each one double as a 128-bit narrow register, so a narrow read and a wide read of the same index always agree on those bits. One port reads the full width and a second port reads only the narrow view. A single write port updates one register per cycle.

Every write carries an encoding class that decides the fate of the upper half. A legacy narrow write leaves bits 255:128 untouched. A prefixed narrow write clears them to zero. A prefixed wide write replaces the whole register. A kill input cancels a write that is in flight, such as one whose operation raised an unmasked exception, and the target register then keeps its old contents. Reads are combinational. A read of the register being written in the same cycle returns the value that the write will leave there.

Top module: `vreg_alias_file`

## Requirements
- R1: `rd_b_narrow` equals bits 127:0 of register `rd_b_idx`, and `rd_a_wide` equals all 256 bits of register `rd_a_idx`.
- R2: A write with class 2'b00 (legacy narrow) stores `wr_data[127:0]` into bits 127:0 and leaves bits 255:128 unchanged.
- R3: A write with class 2'b01 (prefixed narrow) stores `wr_data[127:0]` into bits 127:0 and clears bits 255:128 to zero.
- R4: A write with class 2'b10 (prefixed wide) stores all 256 bits of `wr_data`.
- R5: When `wr_kill` is high, a write of any class leaves the register unchanged.
- R6: A write with the reserved class 2'b11 leaves the register unchanged.
- R7: When `wr_en` is low, no register changes.
- R8: A read in the same cycle as an effective write to the same index returns the value the write stores, including the kept or zeroed upper half, on both ports.
- R9: A synchronous reset (`rst` high at a rising edge) clears all sixteen registers to zero.
- R10: A write changes only the register addressed by `wr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_kill | input | 1 | Cancels the write in this cycle |
| wr_class | input | 2 | Encoding class: 00 legacy narrow, 01 prefixed narrow, 10 prefixed wide, 11 reserved |
| wr_idx | input | 4 | Register written |
| wr_data | input | 256 | Write data; only bits 127:0 are used by narrow classes |
| rd_a_idx | input | 4 | Register read on the wide port |
| rd_a_wide | output | 256 | Full 256-bit register contents |
| rd_b_idx | input | 4 | Register read on the narrow port |
| rd_b_narrow | output | 128 | Bits 127:0 of the register |

## Verification
The hardest case is a legacy narrow write that is bypassed to a reader in the same cycle. The bypass must merge the new low half with an upper half that is already stored, and that upper half is visible only if a wide write put nonzero data there first. The bench therefore loads the register with a distinctive wide value. It then presents a legacy write and a prefixed narrow write with the read index equal to the write index, and samples both ports before the clock edge. Kill and reserved-class writes are also aimed at registers that hold nonzero upper halves, so that a wrongful clear shows up at the ports.

// File: rtl/vreg_alias_file.sv
module vreg_alias_file #(
  parameter int NREG  = 16,
  parameter int WIDTH = 256
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    wr_kill,
  input  logic [1:0]              wr_class,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [WIDTH-1:0]        wr_data,
  input  logic [$clog2(NREG)-1:0] rd_a_idx,
  output logic [WIDTH-1:0]        rd_a_wide,
  input  logic [$clog2(NREG)-1:0] rd_b_idx,
  output logic [WIDTH/2-1:0]      rd_b_narrow
);
  localparam int HALF = WIDTH / 2;
  localparam logic [1:0] CLS_LEGACY = 2'b00;
  localparam logic [1:0] CLS_NARROW = 2'b01;
  localparam logic [1:0] CLS_WIDE   = 2'b10;

  logic [WIDTH-1:0] regs [NREG];
  logic             wr_go;
  logic [HALF-1:0]  new_hi;
  logic [WIDTH-1:0] new_val;

  assign wr_go = wr_en && !wr_kill && (wr_class != 2'b11);

  always_comb begin
    case (wr_class)
      CLS_WIDE:   new_hi = wr_data[WIDTH-1:HALF];
      CLS_NARROW: new_hi = '0;
      default:    new_hi = regs[wr_idx][WIDTH-1:HALF];
    endcase
  end

  assign new_val = {new_hi, wr_data[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_go) begin
      regs[wr_idx] <= new_val;
    end
  end

  assign rd_a_wide   = (wr_go && rd_a_idx == wr_idx) ? new_val : regs[rd_a_idx];
  assign rd_b_narrow = (wr_go && rd_b_idx == wr_idx) ? new_val[HALF-1:0]
                                                     : regs[rd_b_idx][HALF-1:0];

  // R2
  legacy_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_kill && wr_class == CLS_LEGACY) |=>
      regs[$past(wr_idx)][WIDTH-1:HALF] == $past(regs[wr_idx][WIDTH-1:HALF]));

  // R3
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_kill && wr_class == CLS_NARROW) |=>
      regs[$past(wr_idx)][WIDTH-1:HALF] == '0);

  // R4
  wide_full_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_kill && wr_class == CLS_WIDE) |=>
      regs[$past(wr_idx)] == $past(wr_data));

  // R5
  kill_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_kill) |=> regs[$past(wr_idx)] == $past(regs[wr_idx]));

  // R6
  reserved_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_class == 2'b11) |=> regs[$past(wr_idx)] == $past(regs[wr_idx]));

  // R8
  bypass_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_go && rd_a_idx == wr_idx) |-> rd_a_wide[HALF-1:0] == wr_data[HALF-1:0]);
endmodule

// File: tb/sim_vreg_alias_file.sv
module sim_vreg_alias_file;
  logic         clk = 0;
  logic         rst;
  logic         wr_en, wr_kill;
  logic [1:0]   wr_class;
  logic [3:0]   wr_idx, rd_a_idx, rd_b_idx;
  logic [255:0] wr_data, rd_a_wide;
  logic [127:0] rd_b_narrow;
  logic [255:0] model [16];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vreg_alias_file u0 (.clk, .rst, .wr_en, .wr_kill, .wr_class, .wr_idx, .wr_data,
                      .rd_a_idx, .rd_a_wide, .rd_b_idx, .rd_b_narrow);

  function automatic logic [255:0] pat(input int seed);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = seed * 32'h01000193 + i * 32'h9E3779B9 + 32'h1;
    return v;
  endfunction

  function automatic logic [255:0] merge(input logic [1:0] cls, input logic [255:0] old,
                                         input logic [255:0] d);
    case (cls)
      2'b00:   return {old[255:128], d[127:0]};
      2'b01:   return {128'h0, d[127:0]};
      2'b10:   return d;
      default: return old;
    endcase
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input int idx);
    @(negedge clk);
    wr_en = 0; rd_a_idx = idx[3:0]; rd_b_idx = idx[3:0];
    #1;
    chk(req, rd_a_wide, model[idx]);
    chk(req, {128'h0, rd_b_narrow}, {128'h0, model[idx][127:0]});
  endtask

  task automatic wr(input int idx, input logic [1:0] cls, input logic [255:0] d,
                    input logic en, input logic kill);
    @(negedge clk);
    wr_en = en; wr_kill = kill; wr_class = cls; wr_idx = idx[3:0]; wr_data = d;
    if (en && !kill) model[idx] = merge(cls, model[idx], d);
    @(negedge clk);
    wr_en = 0; wr_kill = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) wr(i, 2'b10, pat(i + 50), 1, 0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    for (int i = 0; i < 16; i++) rd_check("R9", i);
  endtask

  task automatic t_wide();
    wr(3, 2'b10, pat(3), 1, 0);
    rd_check("R4", 3);
    @(negedge clk); rd_a_idx = 3; rd_b_idx = 3; #1;
    chk("R1", {128'h0, rd_b_narrow}, {128'h0, rd_a_wide[127:0]});
  endtask

  task automatic t_legacy();
    wr(5, 2'b10, pat(7), 1, 0);
    wr(5, 2'b00, pat(8), 1, 0);
    rd_check("R2", 5);
    chk("R2", {128'h0, model[5][255:128]}, {128'h0, pat(7)[255:128]});
  endtask

  task automatic t_narrow();
    wr(6, 2'b10, pat(9), 1, 0);
    wr(6, 2'b01, pat(10), 1, 0);
    rd_check("R3", 6);
  endtask

  task automatic t_suppress();
    wr(8, 2'b10, pat(11), 1, 0);
    for (int c = 0; c < 3; c++) begin
      wr(8, c[1:0], pat(20 + c), 1, 1);
      rd_check("R5", 8);
    end
    wr(8, 2'b11, pat(30), 1, 0);
    rd_check("R6", 8);
    wr(8, 2'b10, pat(31), 0, 0);
    rd_check("R7", 8);
  endtask

  task automatic t_bypass();
    logic [255:0] e;
    wr(9, 2'b10, pat(40), 1, 0);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      wr_en = 1; wr_kill = 0; wr_class = c[1:0]; wr_idx = 9; wr_data = pat(41 + c);
      rd_a_idx = 9; rd_b_idx = 9;
      e = merge(c[1:0], model[9], pat(41 + c));
      #1;
      chk("R8", rd_a_wide, e);
      chk("R8", {128'h0, rd_b_narrow}, {128'h0, e[127:0]});
      model[9] = e;
      @(negedge clk); wr_en = 0;
    end
    rd_check("R8", 9);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 16; i++) wr(i, 2'b10, pat(100 + i), 1, 0);
    wr(12, 2'b01, pat(200), 1, 0);
    for (int i = 0; i < 16; i++) rd_check("R10", i);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; wr_en = 0; wr_kill = 0; wr_class = 0; wr_idx = 0; wr_data = '0;
    rd_a_idx = 0; rd_b_idx = 0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    rd_check("R9", 0);
    t_reset();
    t_wide();
    t_legacy();
    t_narrow();
    t_suppress();
    t_bypass();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule